// File: doc/BRIEF.md
# Transmit Frame Assembler with Frame Check Sequence

This block turns a payload into a complete transmit frame and hands it out one byte at a time. It emits a run of preamble bytes, a start-of-frame delimiter, a length byte, the payload, and a two-byte frame check sequence. The frame check sequence is computed in hardware as the payload bytes go out. A start request carries the payload length and the delivery mode. Lengths outside the legal range are refused, and nothing is sent for them.

The payload can reach the block in two ways. In packet mode the host fills an internal word buffer through an addressed write port while the block is idle, then issues the start. In stream mode the host offers 16-bit words on the same write port while the frame is going out. A single holding register takes each word, and its low byte is sent before its high byte. If the holding register is empty and no word is offered at the moment a payload byte is due, the frame is abandoned and an underrun pulse is raised.

The output side uses a valid/ready handshake. A one-cycle done pulse marks the acceptance of the final byte.

Top module: `txf_assembler`

## Requirements
- R1: An accepted frame is emitted in this order: four bytes of 0x00, the delimiter 0xA7, the length byte, the payload bytes in index order, then the two check bytes.
- R2: The length byte equals the requested payload length plus 2.
- R3: The check value is a 16-bit CRC that starts at 0x0000 and is fed with the payload bytes only, least significant bit of each byte first. For each bit, the register shifts right one place; when the bit XOR the old bit 0 is 1, it is then XORed with 0x8408. The low byte is sent first, then the high byte.
- R4: A start with length 0 or above 125 raises len_err_o for one cycle, in the cycle after the start is sampled, and no output byte becomes valid.
- R5: In packet mode, buffer word k holds payload byte 2k in bits 7:0 and byte 2k+1 in bits 15:8. Writes are taken only while no frame is in progress, and wr_ready_o is high in that state.
- R6: In stream mode, words are taken in arrival order while wr_ready_o is high, and each is sent low byte first. For an odd length, the high byte of the final word is dropped.
- R7: In stream mode, a payload byte is due while no word is held and none is offered. That frame then ends, and underrun_o pulses in the following cycle with out_valid_o low.
- R8: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_data_o holds its value in the next cycle.
- R9: done_o pulses for one cycle, in the cycle after the second check byte is accepted. At most one of done_o, len_err_o and underrun_o is high in any cycle.
- R10: A start request, or a packet-buffer write, issued while a frame is in progress has no effect on that frame or on the buffer.
- R11: Out of reset, out_valid_o, done_o, len_err_o and underrun_o are low and wr_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled while idle |
| start_len_i | input | 7 | Payload length in bytes |
| start_stream_i | input | 1 | 1 selects stream mode, 0 packet mode |
| wr_valid_i | input | 1 | Payload word offered |
| wr_addr_i | input | 6 | Buffer word address (packet mode) |
| wr_data_i | input | 16 | Payload word, even byte in the low half |
| wr_ready_o | output | 1 | Payload word can be taken this cycle |
| out_valid_o | output | 1 | Output byte valid |
| out_data_o | output | 8 | Output byte |
| out_ready_i | input | 1 | Consumer takes the byte |
| done_o | output | 1 | Frame completed pulse |
| len_err_o | output | 1 | Rejected length pulse |
| underrun_o | output | 1 | Stream underrun pulse |

## Verification
A start sampled at a clock edge makes the first preamble byte valid right after that edge. A rejected length shows len_err_o in that same following cycle. done_o appears one cycle after the edge that takes the last check byte. underrun_o appears two cycles after the edge that takes the final byte of the last word supplied. The bench drives inputs on the falling edge and samples outputs 1 ns later. It counts cycles in that loop and compares each pulse against the cycle index predicted from the last recorded handshake, so a result one cycle early or late is reported.

// File: rtl/txf_pkg.sv
package txf_pkg;
  localparam int TXF_MAX_LEN   = 125;
  localparam int TXF_LEN_W     = $clog2(TXF_MAX_LEN + 1);
  localparam int TXF_WORD_W    = 16;
  localparam int TXF_BUF_WORDS = (TXF_MAX_LEN + 1) / 2;
  localparam int TXF_ADDR_W    = $clog2(TXF_BUF_WORDS);
  localparam logic [15:0] TXF_CRC_MASK = 16'h8408;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_SFD,
    PH_LEN,
    PH_PAY,
    PH_FCS0,
    PH_FCS1
  } txf_phase_e;
endpackage

// File: rtl/txf_pktbuf.sv
module txf_pktbuf
  import txf_pkg::*;
(
  input  logic                  clk,
  input  logic                  wr_en_i,
  input  logic [TXF_ADDR_W-1:0] wr_addr_i,
  input  logic [TXF_WORD_W-1:0] wr_data_i,
  input  logic [TXF_ADDR_W-1:0] rd_addr_i,
  output logic [TXF_WORD_W-1:0] rd_data_o
);
  localparam logic [TXF_ADDR_W-1:0] LAST_ADDR = TXF_ADDR_W'(TXF_BUF_WORDS - 1);

  logic [TXF_WORD_W-1:0] mem_q [TXF_BUF_WORDS];
  logic                  wr_hit;

  assign wr_hit = wr_en_i && (wr_addr_i <= LAST_ADDR);

  always_ff @(posedge clk) begin
    if (wr_hit) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  always_comb begin
    if (rd_addr_i <= LAST_ADDR) rd_data_o = mem_q[rd_addr_i];
    else                        rd_data_o = '0;
  end
endmodule

// File: rtl/txf_hold.sv
module txf_hold
  import txf_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  need_i,
  input  logic                  consume_i,
  input  logic                  wr_valid_i,
  input  logic [TXF_WORD_W-1:0] wr_data_i,
  output logic                  ready_o,
  output logic                  load_o,
  output logic                  full_o,
  output logic [TXF_WORD_W-1:0] word_o
);
  logic                  full_q, full_d;
  logic [TXF_WORD_W-1:0] word_q;

  assign ready_o = need_i && (!full_q || consume_i);
  assign load_o  = ready_o && wr_valid_i;

  always_comb begin
    full_d = full_q;
    if (load_o)         full_d = 1'b1;
    else if (consume_i) full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  always_ff @(posedge clk) begin
    if (load_o) word_q <= wr_data_i;
  end

  assign full_o = full_q;
  assign word_o = word_q;
endmodule

// File: rtl/txf_crc16.sv
module txf_crc16
  import txf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr_i,
  input  logic        upd_i,
  input  logic [7:0]  byte_i,
  output logic [15:0] crc_o
);
  logic [15:0] crc_q, crc_d, crc_step;

  always_comb begin
    crc_step = crc_q;
    for (int b = 0; b < 8; b++) begin
      if (crc_step[0] ^ byte_i[b]) crc_step = (crc_step >> 1) ^ TXF_CRC_MASK;
      else                         crc_step = crc_step >> 1;
    end
  end

  always_comb begin
    crc_d = crc_q;
    if (clr_i)      crc_d = '0;
    else if (upd_i) crc_d = crc_step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else        crc_q <= crc_d;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/txf_ctrl.sv
module txf_ctrl
  import txf_pkg::*;
#(
  parameter int PRE_BYTES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [TXF_LEN_W-1:0] start_len_i,
  input  logic                 start_stream_i,
  input  logic                 out_ready_i,
  input  logic                 hold_full_i,
  input  logic                 word_in_i,
  output txf_phase_e           phase_o,
  output logic                 out_valid_o,
  output logic [TXF_LEN_W-1:0] bidx_o,
  output logic [TXF_LEN_W-1:0] len_o,
  output logic                 strm_o,
  output logic                 crc_clr_o,
  output logic                 crc_upd_o,
  output logic                 consume_o,
  output logic                 need_word_o,
  output logic                 done_o,
  output logic                 err_o,
  output logic                 und_o
);
  localparam int PRE_W = (PRE_BYTES > 1) ? $clog2(PRE_BYTES) : 1;
  localparam logic [PRE_W-1:0]     PRE_LAST = PRE_W'(PRE_BYTES - 1);
  localparam logic [TXF_LEN_W-1:0] LEN_MAX  = TXF_LEN_W'(TXF_MAX_LEN);

  txf_phase_e           st_q, st_d;
  logic [PRE_W-1:0]     pre_q, pre_d;
  logic [TXF_LEN_W-1:0] bidx_q, bidx_d;
  logic [TXF_LEN_W-1:0] len_q, len_d;
  logic [TXF_LEN_W-1:0] wleft_q, wleft_d;
  logic                 strm_q, strm_d;
  logic                 done_q, done_d, err_q, err_d, und_q, und_d;

  logic                 len_legal, start_ok, start_bad;
  logic                 fire, last_pay, underrun_now;
  logic [TXF_LEN_W:0]   len_plus1;

  assign len_legal    = (start_len_i != '0) && (start_len_i <= LEN_MAX);
  assign start_ok     = (st_q == PH_IDLE) && start_i && len_legal;
  assign start_bad    = (st_q == PH_IDLE) && start_i && !len_legal;
  assign len_plus1    = {1'b0, start_len_i} + (TXF_LEN_W+1)'(1);

  assign out_valid_o  = (st_q != PH_IDLE) && !((st_q == PH_PAY) && strm_q && !hold_full_i);
  assign fire         = out_valid_o && out_ready_i;
  assign last_pay     = (bidx_q == (len_q - TXF_LEN_W'(1)));
  assign underrun_now = (st_q == PH_PAY) && strm_q && !hold_full_i && !word_in_i;

  assign crc_clr_o    = start_ok;
  assign crc_upd_o    = fire && (st_q == PH_PAY);
  assign consume_o    = fire && (st_q == PH_PAY) && strm_q && (bidx_q[0] || last_pay);
  assign need_word_o  = (st_q != PH_IDLE) && strm_q && (wleft_q != '0);

  always_comb begin
    st_d    = st_q;
    pre_d   = pre_q;
    bidx_d  = bidx_q;
    len_d   = len_q;
    strm_d  = strm_q;
    wleft_d = wleft_q;
    done_d  = 1'b0;
    err_d   = start_bad;
    und_d   = 1'b0;

    if (word_in_i && (wleft_q != '0)) wleft_d = wleft_q - TXF_LEN_W'(1);

    case (st_q)
      PH_IDLE: begin
        if (start_ok) begin
          st_d    = PH_PRE;
          pre_d   = '0;
          bidx_d  = '0;
          len_d   = start_len_i;
          strm_d  = start_stream_i;
          wleft_d = start_stream_i ? len_plus1[TXF_LEN_W:1] : '0;
        end
      end
      PH_PRE: begin
        if (fire) begin
          if (pre_q == PRE_LAST) st_d = PH_SFD;
          else                   pre_d = pre_q + PRE_W'(1);
        end
      end
      PH_SFD:  if (fire) st_d = PH_LEN;
      PH_LEN:  if (fire) st_d = PH_PAY;
      PH_PAY: begin
        if (underrun_now) begin
          st_d    = PH_IDLE;
          und_d   = 1'b1;
          wleft_d = '0;
        end else if (fire) begin
          if (last_pay) st_d = PH_FCS0;
          else          bidx_d = bidx_q + TXF_LEN_W'(1);
        end
      end
      PH_FCS0: if (fire) st_d = PH_FCS1;
      PH_FCS1: begin
        if (fire) begin
          st_d   = PH_IDLE;
          done_d = 1'b1;
        end
      end
      default: st_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= PH_IDLE;
      pre_q   <= '0;
      bidx_q  <= '0;
      len_q   <= '0;
      strm_q  <= 1'b0;
      wleft_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      und_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      pre_q   <= pre_d;
      bidx_q  <= bidx_d;
      len_q   <= len_d;
      strm_q  <= strm_d;
      wleft_q <= wleft_d;
      done_q  <= done_d;
      err_q   <= err_d;
      und_q   <= und_d;
    end
  end

  assign phase_o = st_q;
  assign bidx_o  = bidx_q;
  assign len_o   = len_q;
  assign strm_o  = strm_q;
  assign done_o  = done_q;
  assign err_o   = err_q;
  assign und_o   = und_q;
endmodule

// File: rtl/txf_assembler.sv
module txf_assembler
  import txf_pkg::*;
#(
  parameter int         PRE_BYTES = 4,
  parameter logic [7:0] PRE_BYTE  = 8'h00,
  parameter logic [7:0] SFD_BYTE  = 8'hA7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [TXF_LEN_W-1:0]  start_len_i,
  input  logic                  start_stream_i,
  input  logic                  wr_valid_i,
  input  logic [TXF_ADDR_W-1:0] wr_addr_i,
  input  logic [TXF_WORD_W-1:0] wr_data_i,
  output logic                  wr_ready_o,
  output logic                  out_valid_o,
  output logic [7:0]            out_data_o,
  input  logic                  out_ready_i,
  output logic                  done_o,
  output logic                  len_err_o,
  output logic                  underrun_o
);
  txf_phase_e            phase;
  logic [TXF_LEN_W-1:0]  bidx, len;
  logic                  strm, crc_clr, crc_upd, consume, need_word;
  logic                  hold_ready, hold_load, hold_full;
  logic [TXF_WORD_W-1:0] hold_word, buf_word, src_word;
  logic [15:0]           crc;
  logic                  idle, buf_wr;
  logic [7:0]            pay_byte;

  assign idle   = (phase == PH_IDLE);
  assign buf_wr = idle && wr_valid_i;

  txf_ctrl #(.PRE_BYTES(PRE_BYTES)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .start_len_i    (start_len_i),
    .start_stream_i (start_stream_i),
    .out_ready_i    (out_ready_i),
    .hold_full_i    (hold_full),
    .word_in_i      (hold_load),
    .phase_o        (phase),
    .out_valid_o    (out_valid_o),
    .bidx_o         (bidx),
    .len_o          (len),
    .strm_o         (strm),
    .crc_clr_o      (crc_clr),
    .crc_upd_o      (crc_upd),
    .consume_o      (consume),
    .need_word_o    (need_word),
    .done_o         (done_o),
    .err_o          (len_err_o),
    .und_o          (underrun_o)
  );

  txf_pktbuf u_buf (
    .clk       (clk),
    .wr_en_i   (buf_wr),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (bidx[TXF_LEN_W-1:1]),
    .rd_data_o (buf_word)
  );

  txf_hold u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .need_i     (need_word),
    .consume_i  (consume),
    .wr_valid_i (wr_valid_i),
    .wr_data_i  (wr_data_i),
    .ready_o    (hold_ready),
    .load_o     (hold_load),
    .full_o     (hold_full),
    .word_o     (hold_word)
  );

  txf_crc16 u_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (crc_clr),
    .upd_i  (crc_upd),
    .byte_i (out_data_o),
    .crc_o  (crc)
  );

  assign wr_ready_o = idle || hold_ready;
  assign src_word   = strm ? hold_word : buf_word;
  assign pay_byte   = bidx[0] ? src_word[15:8] : src_word[7:0];

  always_comb begin
    case (phase)
      PH_PRE:  out_data_o = PRE_BYTE;
      PH_SFD:  out_data_o = SFD_BYTE;
      PH_LEN:  out_data_o = 8'(len) + 8'd2;
      PH_PAY:  out_data_o = pay_byte;
      PH_FCS0: out_data_o = crc[7:0];
      PH_FCS1: out_data_o = crc[15:8];
      default: out_data_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/txf_checker.sv
module txf_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       out_valid_o,
  input logic       out_ready_i,
  input logic [7:0] out_data_o,
  input logic       done_o,
  input logic       len_err_o,
  input logic       underrun_o
);
  p_hold_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

  p_done_after_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(out_valid_o && out_ready_i));

  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, len_err_o, underrun_o}));

  p_reject_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    len_err_o |-> (!out_valid_o && $past(start_i)));

  p_underrun_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_o |-> !out_valid_o);
endmodule

bind txf_assembler txf_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .done_o      (done_o),
  .len_err_o   (len_err_o),
  .underrun_o  (underrun_o)
);

// File: tb/tb_txf_assembler.sv
module tb_txf_assembler;
  localparam int CLK_PERIOD = 10;
  localparam int VEC_N = 6;
  // {stream, length, seed, backpressure}
  localparam int VEC [VEC_N][4] = '{
    '{0, 1,   3,  0},
    '{0, 125, 5,  1},
    '{1, 2,   7,  0},
    '{1, 7,   9,  1},
    '{0, 10,  11, 1},
    '{1, 125, 13, 1}
  };

  logic        clk, rst_n;
  logic        start_i, start_stream_i;
  logic [6:0]  start_len_i;
  logic        wr_valid_i;
  logic [5:0]  wr_addr_i;
  logic [15:0] wr_data_i;
  logic        wr_ready_o, out_valid_o, out_ready_i;
  logic [7:0]  out_data_o;
  logic        done_o, len_err_o, underrun_o;

  int checks = 0;
  int fails  = 0;
  logic [7:0] got [0:255];
  int nget, done_cyc, und_cyc, last_fire;

  txf_assembler dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_len_i(start_len_i),
    .start_stream_i(start_stream_i), .wr_valid_i(wr_valid_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .wr_ready_o(wr_ready_o), .out_valid_o(out_valid_o),
    .out_data_o(out_data_o), .out_ready_i(out_ready_i), .done_o(done_o),
    .len_err_o(len_err_o), .underrun_o(underrun_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] pb(int seed, int i);
    if (seed == 999) return 8'(8'h31 + i);
    return 8'(seed * 37 + i * 13 + 5);
  endfunction

  function automatic logic [15:0] pword(int seed, int k);
    return {pb(seed, 2*k+1), pb(seed, 2*k)};
  endfunction

  function automatic logic [15:0] fcs(int seed, int len);
    logic [15:0] c = 16'h0000;
    for (int i = 0; i < len; i++) begin
      logic [7:0] b = pb(seed, i);
      for (int k = 0; k < 8; k++) begin
        if (c[0] ^ b[k]) c = (c >> 1) ^ 16'h8408;
        else             c = c >> 1;
      end
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic load_packet(input int seed, input int len);
    for (int k = 0; k < (len + 1) / 2; k++) begin
      @(negedge clk);
      wr_valid_i = 1'b1; wr_addr_i = 6'(k); wr_data_i = pword(seed, k);
    end
    @(negedge clk);
    wr_valid_i = 1'b0;
  endtask

  task automatic run_frame(input bit strm, input int len, input int seed, input int bp,
                           input bit junk, input int feed_words);
    int nw = 0;
    nget = 0; done_cyc = -1; und_cyc = -1; last_fire = -1;
    @(negedge clk);
    start_i = 1'b1; start_len_i = 7'(len); start_stream_i = strm; wr_valid_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      out_ready_i = (bp == 0) || ((cyc % 3) != 1);
      wr_valid_i = 1'b0;
      if (strm && nw < feed_words) begin
        wr_valid_i = 1'b1; wr_data_i = pword(seed, nw);
      end
      if (junk && cyc == 7) begin start_i = 1'b1; start_len_i = 7'd3; end
      if (junk && !strm && cyc == 8) begin
        wr_valid_i = 1'b1; wr_addr_i = 6'd0; wr_data_i = 16'hDEAD;
      end
      #1;
      if (strm && wr_valid_i && wr_ready_o) nw++;
      if (out_valid_o && out_ready_i) begin
        got[nget] = out_data_o; nget++; last_fire = cyc;
      end
      if (done_o && done_cyc < 0) done_cyc = cyc;
      if (underrun_o && und_cyc < 0) und_cyc = cyc;
      if (done_o || underrun_o) break;
      @(negedge clk);
      start_i = 1'b0;
    end
    wr_valid_i = 1'b0; out_ready_i = 1'b0; start_i = 1'b0;
  endtask

  task automatic check_frame(input int len, input int seed);
    logic [7:0] exp [0:255];
    logic [15:0] c = fcs(seed, len);
    int n = len + 8;
    for (int i = 0; i < 4; i++) exp[i] = 8'h00;            // R1
    exp[4] = 8'hA7;                                          // R1
    exp[5] = 8'(len + 2);                                    // R2
    for (int i = 0; i < len; i++) exp[6+i] = pb(seed, i);    // R5 R6
    exp[6+len] = c[7:0];                                     // R3
    exp[7+len] = c[15:8];                                    // R3
    chk(nget == n, "R1 byte count", nget, n);
    for (int i = 0; i < n && i < nget; i++)
      chk(got[i] == exp[i], (i == 5) ? "R2 length byte" : (i >= 6 + len) ? "R3 fcs" : "R1 frame byte",
          got[i], exp[i]);
    chk(done_cyc == last_fire + 1, "R9 done timing", done_cyc, last_fire + 1);
  endtask

  task automatic reject(input int len);
    @(negedge clk);
    start_i = 1'b1; start_len_i = 7'(len); start_stream_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    #1;
    chk(len_err_o == 1'b1, "R4 err pulse", len_err_o, 1);
    chk(out_valid_o == 1'b0, "R4 no output", out_valid_o, 0);
    @(negedge clk); #1;
    chk(len_err_o == 1'b0 && out_valid_o == 1'b0, "R4 quiet after", {len_err_o, out_valid_o}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; start_len_i = '0; start_stream_i = 1'b0;
    wr_valid_i = 1'b0; wr_addr_i = '0; wr_data_i = '0; out_ready_i = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R11 reset state
    chk(out_valid_o == 1'b0, "R11 valid low", out_valid_o, 0);
    chk({done_o, len_err_o, underrun_o} == 3'b000, "R11 pulses low", {done_o, len_err_o, underrun_o}, 0);
    chk(wr_ready_o == 1'b1, "R11 ready high", wr_ready_o, 1);
    @(negedge clk);
    rst_n = 1'b1;

    for (int v = 0; v < VEC_N; v++) begin
      int s = VEC[v][0], l = VEC[v][1], sd = VEC[v][2], b = VEC[v][3];
      if (s == 0) load_packet(sd, l);
      run_frame(s[0], l, sd, b, 1'b0, (l + 1) / 2);
      check_frame(l, sd);
    end

    // R3 known answer: payload "123456789" gives 0x2189
    load_packet(999, 9);
    run_frame(1'b0, 9, 999, 0, 1'b0, 0);
    chk(nget == 17 && got[15] == 8'h89 && got[16] == 8'h21, "R3 known answer",
        {got[15], got[16]}, 16'h8921);

    // R4 rejected lengths
    reject(0);
    reject(126);

    // R10 start and buffer write during a frame are ignored
    load_packet(21, 6);
    run_frame(1'b0, 6, 21, 0, 1'b1, 0);
    check_frame(6, 21);
    run_frame(1'b0, 6, 21, 1, 1'b0, 0);
    check_frame(6, 21);   // R5 buffer untouched by the busy write

    // R6 odd stream length with backpressure
    run_frame(1'b1, 3, 17, 1, 1'b0, 2);
    check_frame(3, 17);

    // R7 stream underrun after one word of a four-byte payload
    run_frame(1'b1, 4, 19, 0, 1'b0, 1);
    chk(nget == 8, "R7 bytes before abort", nget, 8);
    chk(und_cyc == last_fire + 2, "R7 underrun timing", und_cyc, last_fire + 2);
    chk(done_cyc == -1, "R7 no done", done_cyc, -1);
    @(negedge clk); #1;
    chk(out_valid_o == 1'b0 && underrun_o == 1'b0, "R7 idle after", {out_valid_o, underrun_o}, 0);

    // R8 backpressure hold on a fresh frame's first byte
    @(negedge clk);
    start_i = 1'b1; start_len_i = 7'd2; start_stream_i = 1'b0; out_ready_i = 1'b0;
    @(negedge clk); start_i = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk(out_valid_o == 1'b1 && out_data_o == 8'h00, "R8 held byte", {out_valid_o, out_data_o}, 16'h100);
    out_ready_i = 1'b1;
    repeat (20) @(negedge clk);
    out_ready_i = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule